// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block is the host-side bus of a 16-bit parallel flash memory. Each clock it samples four active-low strobes: chip select, output enable, write enable and a bus reset. From these it decides whether the cycle is a read, a command write, standby, output disable or reset. The 16-bit data bus is modelled as three separate signals: an output value, a per-pin output enable and an input value. A width-select pin picks word or byte operation.

Reads return a word from a small internal array. The array's contents are a fixed function of the word address. In byte mode the top data pin stops carrying data and acts as the least-significant address bit. That bit picks which half of the addressed word appears on the low eight pins. Writes never change the array. A write is latched as a command: address, data and a one-cycle valid pulse are passed to a downstream command state machine.

After a bus reset or a system reset, the block returns to array-read mode. A command write can switch reads to echo mode, where they return the last captured command word. Writing the exit code returns reads to the array.

Top module: `flash_bus_front`

## Requirements
- R1: A read cycle is chip select low, output enable low, write enable high and bus reset high. One clock after such a sampled cycle, the addressed data is driven and its pins are enabled.
- R2: In array mode, the word at word address `a` is `{a8, ~a8} ^ ARR_KEY`, where `a8` is `a` resized to 8 bits.
- R3: A write cycle is chip select low, write enable low, output enable high and bus reset high. One clock after the first sampled cycle of a write, `cmd_valid` is high for exactly one cycle. A write held for several cycles gives only one pulse. The captured fields hold until the next capture.
- R4: One clock after any cycle sampled with chip select high, every data pin is undriven, whatever the other strobes are.
- R5: Chip select low with both output enable and write enable high leaves all pins undriven. Chip select low with both output enable and write enable low is illegal: all pins are undriven and no command is captured.
- R6: While bus reset is low, all pins are undriven one clock later, writes are ignored, and reads go back to array mode.
- R7: In word mode (`word_mode`=1), a read drives all 16 pins with the full word.
- R8: In byte mode (`word_mode`=0), a read drives only pins 0..7. `dq_in[15]`=0 selects bits 7..0 of the word and `dq_in[15]`=1 selects bits 15..8. Every pin that is not driven outputs 0.
- R9: A captured byte write gives `cmd_addr`=`{addr, dq_in[15]}`, `cmd_data`=`{8'h00, dq_in[7:0]}` and `cmd_byte`=1. A captured word write gives `cmd_addr`=`{addr, 1'b0}`, `cmd_data`=`dq_in` and `cmd_byte`=0.
- R10: A captured command whose low data byte is not `RESET_CMD` (0xF0) switches reads to echo mode. In echo mode reads return the last captured `cmd_data` instead of array data, with the same width steering. A captured `RESET_CMD` returns reads to array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, asynchronous, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| reset_n | input | 1 | Bus reset strobe, active low |
| word_mode | input | 1 | 1 = word width, 0 = byte width |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data bus input; bit 15 is the byte-select address bit in byte mode |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-pin output enable |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | ADDR_W+1 | Captured byte address |
| cmd_data | output | 16 | Captured command data |
| cmd_byte | output | 1 | Captured command was a byte write |

## Verification
The bench builds the block with `ADDR_W`=6, which gives 64 word addresses. Every word address and both byte halves of each can then be swept with a few hundred cycles, so R2 and R8 are checked over the whole array rather than a sample. `ARR_KEY` and `RESET_CMD` keep their default values, so the echo-mode exit code exercised is the same one a default build uses.

// File: rtl/flash_bus_front.sv
module flash_bus_front #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] ARR_KEY   = 16'hC33C,
  parameter logic [7:0]  RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              reset_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [15:0]       cmd_data,
  output logic              cmd_byte
);

  localparam int BYTE_W = 8;

  logic rd_cyc, wr_cyc, wr_q, echo_mode, wr_start;
  logic [15:0] last_cmd, src_word, arr_word, wr_word;
  logic [BYTE_W-1:0] a8, half;

  assign rd_cyc   = reset_n & ~ce_n & ~oe_n & we_n;
  assign wr_cyc   = reset_n & ~ce_n & oe_n & ~we_n;
  assign wr_start = wr_cyc & ~wr_q;

  assign a8       = BYTE_W'(addr);
  assign arr_word = {a8, ~a8} ^ ARR_KEY;
  assign src_word = echo_mode ? last_cmd : arr_word;
  assign half     = dq_in[15] ? src_word[15:8] : src_word[7:0];
  assign wr_word  = word_mode ? dq_in : {8'h00, dq_in[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= '0;
      dq_out <= '0;
    end else if (rd_cyc) begin
      dq_oe  <= word_mode ? 16'hFFFF : 16'h00FF;
      dq_out <= word_mode ? src_word : {8'h00, half};
    end else begin
      dq_oe  <= '0;
      dq_out <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_byte  <= 1'b0;
      echo_mode <= 1'b0;
      last_cmd  <= '0;
    end else begin
      wr_q      <= wr_cyc;
      cmd_valid <= wr_start;
      if (!reset_n) begin
        echo_mode <= 1'b0;
      end else if (wr_start) begin
        cmd_addr  <= {addr, word_mode ? 1'b0 : dq_in[15]};
        cmd_data  <= wr_word;
        cmd_byte  <= ~word_mode;
        last_cmd  <= wr_word;
        echo_mode <= (wr_word[7:0] != RESET_CMD);
      end
    end
  end

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> dq_oe == 16'h0000); // R4
  AST_BUS_RESET_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reset_n) |-> (dq_oe == 16'h0000 && !cmd_valid)); // R6
  AST_ILLEGAL_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ce_n && !oe_n && !we_n) |-> (dq_oe == 16'h0000 && !cmd_valid)); // R5
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R3
  AST_BYTE_UPPER_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe[15:8] != 8'h00) |-> $past(word_mode)); // R8
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ($stable(cmd_data) && $stable(cmd_addr) && $stable(cmd_byte))); // R3
  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out & ~dq_oe) == 16'h0000); // R8

endmodule

// File: tb/flash_bus_front_tb_top.sv
module flash_bus_front_tb_top;
  localparam int AW = 6;
  localparam logic [15:0] KEY = 16'hC33C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reset_n = 1'b1, word_mode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out, dq_oe, cmd_data;
  logic cmd_valid, cmd_byte;
  logic [AW:0] cmd_addr;

  int tests = 0, fails = 0;
  bit finished = 0;

  logic [15:0] e_oe = 0, e_out = 0, e_data = 0, m_last = 0;
  logic [AW:0] e_addr = 0;
  logic e_valid = 0, e_byte = 0, m_echo = 0, m_prevwr = 0;

  always #2 clk = ~clk;

  flash_bus_front #(.ADDR_W(AW), .ARR_KEY(KEY), .RESET_CMD(8'hF0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .reset_n(reset_n), .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_byte(cmd_byte));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] arr(input logic [AW-1:0] a);
    logic [7:0] b = {2'b00, a};
    return {b, ~b} ^ KEY;
  endfunction

  task automatic model();
    bit rd = reset_n && !ce_n && !oe_n && we_n;
    bit wr = reset_n && !ce_n && oe_n && !we_n;
    logic [15:0] w = m_echo ? m_last : arr(addr);
    logic [15:0] wd = word_mode ? dq_in : {8'h00, dq_in[7:0]};
    if (rd) begin
      e_oe  = word_mode ? 16'hFFFF : 16'h00FF;
      e_out = word_mode ? w : {8'h00, (dq_in[15] ? w[15:8] : w[7:0])};
    end else begin
      e_oe = 0; e_out = 0;
    end
    e_valid = wr && !m_prevwr;
    if (!reset_n) m_echo = 0;
    else if (e_valid) begin
      e_addr = {addr, word_mode ? 1'b0 : dq_in[15]};
      e_data = wd; e_byte = !word_mode; m_last = wd;
      m_echo = (wd[7:0] != 8'hF0);
    end
    m_prevwr = wr;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    chk(dq_oe === e_oe, {tag, " R4 R5 R6 R7 R8 oe"}, dq_oe, e_oe);
    chk(dq_out === e_out, {tag, " R1 R2 R10 data"}, dq_out, e_out);
    chk(cmd_valid === e_valid, {tag, " R3 valid"}, cmd_valid, e_valid);
    chk(cmd_addr === e_addr && cmd_data === e_data && cmd_byte === e_byte,
        {tag, " R9 fields"}, {cmd_byte, cmd_addr, cmd_data}, {e_byte, e_addr, e_data});
  endtask

  task automatic bus(input logic c, input logic o, input logic w, input logic r,
                     input logic wm, input logic [AW-1:0] a, input logic [15:0] d);
    ce_n = c; oe_n = o; we_n = w; reset_n = r; word_mode = wm; addr = a; dq_in = d;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dq_oe === 16'h0 && cmd_valid === 1'b0, "R6 reset state", {dq_oe, 15'h0, cmd_valid}, 32'h0);
    rst_n = 1'b1;
    // R1 R2 R7: full word sweep
    for (int i = 0; i < 64; i++) begin bus(0, 0, 1, 1, 1, AW'(i), 0); step("R1 R2 R7 word read"); end
    // R8: both halves
    for (int i = 0; i < 64; i++) begin
      bus(0, 0, 1, 1, 0, AW'(i), 16'h0000); step("R8 byte low");
      bus(0, 0, 1, 1, 0, AW'(i), 16'hFFFF); step("R8 byte high");
    end
    // R4 standby for every strobe combination
    for (int i = 0; i < 8; i++) begin bus(1, i[0], i[1], 1, i[2], 6'd5, 16'h1234); step("R4 standby"); end
    bus(0, 1, 1, 1, 1, 6'd9, 0); step("R5 output disable");
    bus(0, 0, 0, 1, 1, 6'd9, 16'h0011); step("R5 illegal"); step("R5 illegal held");
    // R3 R9 word write held, then echo R10
    bus(0, 1, 0, 1, 1, 6'd17, 16'hBEEF); step("R3 write start"); step("R3 held"); step("R3 held");
    bus(0, 1, 1, 1, 1, 6'd17, 0); step("R3 idle");
    bus(0, 0, 1, 1, 1, 6'd2, 0); step("R10 echo word");
    bus(0, 0, 1, 1, 0, 6'd2, 16'h8000); step("R10 echo high byte");
    // byte write R9
    bus(0, 1, 0, 1, 0, 6'd33, 16'h80A7); step("R9 byte write");
    bus(1, 1, 1, 1, 1, 0, 0); step("R9 gap");
    // exit code R10
    bus(0, 1, 0, 1, 0, 6'd1, 16'h00F0); step("R10 exit cmd");
    bus(0, 0, 1, 1, 1, 6'd3, 0); step("R10 back to array");
    // R6 bus reset clears echo, ignores writes
    bus(0, 1, 0, 1, 1, 6'd4, 16'h1111); step("R6 enter echo");
    bus(0, 1, 0, 0, 1, 6'd4, 16'h2222); step("R6 write under reset");
    bus(0, 0, 1, 0, 1, 6'd4, 0); step("R6 read under reset");
    bus(0, 0, 1, 1, 1, 6'd4, 0); step("R6 array after reset");
    for (int i = 0; i < 400; i++) begin
      bus($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
          $urandom_range(0, 9) != 0, $urandom_range(0, 1), AW'($urandom),
          ($urandom_range(0, 3) == 0) ? 16'h00F0 : 16'($urandom));
      step("R1 R3 R10 random");
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule